// File: doc/BRIEF.md
# Two-Vector Byte Interleave Network

This block permutes the bytes of two equal-width vectors by running them through a chain of butterfly stages. There is one stage for each bit of the byte index, and the stages run from the narrowest stride to the widest. A control word switches each stage on or off on its own. An enabled stage at stride s trades bytes between the two vectors: a byte of the first vector whose index has bit s clear changes places with the byte of the second vector that sits s positions higher. A disabled stage lets both vectors through unchanged.

A caller may name one register as both operands. In that case it raises `same_operand`, and the network treats each operand as its own copy of `vec_a` while ignoring `vec_b`. The value the caller writes back to that register is `out_b`.

When `REGISTERED` is 1 (the default), the results are captured on the clock edge after `in_valid`. A two-state machine then reports them with `out_valid` for one cycle:
- **ST_EMPTY**: no fresh result. It goes to ST_FULL when `in_valid` is high (transition *accept*) and stays put otherwise (*idle*).
- **ST_FULL**: a result captured on the last edge is being shown. It stays in ST_FULL on `in_valid` (*chain*) and returns to ST_EMPTY without it (*drain*).

When `REGISTERED` is 0, the network is purely combinational and `out_valid` follows `in_valid`.

Top module: `byte_shuffle_net`

## Requirements
- R1: Enabled stages are applied in order of increasing stride (1, 2, 4, … up to NBYTES/2). Each stage works on the output of the previous one.
- R2: The stage at stride s is enabled only by control bit index s. For NBYTES=16, bits 1, 2, 4 and 8 are used.
- R3: In an enabled stage at stride s, for each byte index k with (k & s)==0, byte k of the first vector and byte k+s of the second vector are exchanged. All other bytes keep their place. Byte k is bits [8k+7:8k].
- R4: Control bits whose index is not a stride have no effect on either output. These are bit 0 and every index that is not a power of two.
- R5: When all stride bits of the control word are zero, `out_a` equals `vec_a` and `out_b` equals `vec_b` exactly.
- R6: When `same_operand` is 1, both network inputs take the value of `vec_a`, and `vec_b` has no effect on either output.
- R7: With REGISTERED=1, `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. The outputs show the result for the inputs of that earlier cycle.
- R8: With REGISTERED=1, a cycle with `in_valid` low leaves `out_a` and `out_b` unchanged on the next edge.
- R9: During and right after reset, `out_valid`, `out_a` and `out_b` are all zero.
- R10: The XOR of all bytes of both outputs equals the XOR of all bytes of both network inputs, because the network only moves bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and control are presented this cycle |
| vec_a | input | NBYTES*8 | First operand |
| vec_b | input | NBYTES*8 | Second operand, ignored when same_operand is 1 |
| ctrl | input | NBYTES | Stage enables, bit s enables stride s |
| same_operand | input | 1 | Both operands are one register; use vec_a for both |
| out_valid | output | 1 | Result is valid this cycle |
| out_a | output | NBYTES*8 | Permuted first vector |
| out_b | output | NBYTES*8 | Permuted second vector (write-back value when aliased) |

## Verification
The operands use a distinct counting pattern in every byte, so any misplaced byte changes the compared value.

The control words used are:
- **Zero.** Proves the identity.
- **Each single stride bit.** Isolates the exchange rule at each stride.
- **Only non-stride bits.** Shows they are ignored.
- **All stride bits together and random mixes.** Tell a correct stage order from a reversed one, because butterfly stages do not commute.

Aliased-operand cases put garbage on `vec_b` to show it is not used. Idle cycles with changing inputs between vectors separate a holding output register from a transparent one.

// File: rtl/shuf_pkg.sv
`timescale 1ns/1ps
package shuf_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hold_state_e;

    // mask of control bits that select a real stride
    function automatic logic [63:0] stride_mask(input int nbytes);
        logic [63:0] m;
        m = '0;
        for (int s = 1; s < nbytes; s = s * 2) m[s] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/shuf_stage.sv
`timescale 1ns/1ps
module shuf_stage #(
    parameter int NBYTES = 16,
    parameter int STRIDE = 1,
    localparam int W = NBYTES * shuf_pkg::BYTE_W
) (
    input  logic         en,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o
);
    localparam int BW = shuf_pkg::BYTE_W;

    always_comb begin
        a_o = a_i;
        b_o = b_i;
        if (en) begin
            for (int k = 0; k < NBYTES; k++) begin
                if ((k & STRIDE) == 0) begin
                    a_o[k*BW +: BW]          = b_i[(k+STRIDE)*BW +: BW];
                    b_o[(k+STRIDE)*BW +: BW] = a_i[k*BW +: BW];
                end
            end
        end
    end
endmodule

// File: rtl/shuf_net.sv
`timescale 1ns/1ps
module shuf_net #(
    parameter int NBYTES = 16,
    localparam int W = NBYTES * shuf_pkg::BYTE_W,
    localparam int NSTAGE = $clog2(NBYTES)
) (
    input  logic [NBYTES-1:0] ctrl,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    output logic [W-1:0]      a_o,
    output logic [W-1:0]      b_o
);
    localparam logic [NBYTES-1:0] MASK = NBYTES'(shuf_pkg::stride_mask(NBYTES));

    logic [W-1:0] a_c [NSTAGE+1];
    logic [W-1:0] b_c [NSTAGE+1];
    logic         ctrl_unused;

    assign ctrl_unused = ^(ctrl & ~MASK);
    assign a_c[0] = a_i;
    assign b_c[0] = b_i;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        shuf_stage #(.NBYTES(NBYTES), .STRIDE(1 << g)) stage_i (
            .en  (ctrl[1 << g]),
            .a_i (a_c[g]),
            .b_i (b_c[g]),
            .a_o (a_c[g+1]),
            .b_o (b_c[g+1])
        );
    end

    assign a_o = a_c[NSTAGE];
    assign b_o = b_c[NSTAGE];
endmodule

// File: rtl/shuf_outreg.sv
`timescale 1ns/1ps
module shuf_outreg #(
    parameter int W = 128,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         out_valid,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o
);
    import shuf_pkg::*;

    if (REGISTERED) begin : g_reg
        hold_state_e state_q, state_d;
        logic [W-1:0] a_q, b_q;

        always_comb begin
            state_d = state_q;
            unique case (state_q)
                ST_EMPTY: if (in_valid)  state_d = ST_FULL;   // accept
                ST_FULL:  if (!in_valid) state_d = ST_EMPTY;  // drain
                default:  state_d = ST_EMPTY;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) state_q <= ST_EMPTY;
            else        state_q <= state_d;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q <= '0;
                b_q <= '0;
            end else if (in_valid) begin
                a_q <= a_i;
                b_q <= b_i;
            end
        end

        assign out_valid = (state_q == ST_FULL);
        assign a_o = a_q;
        assign b_o = b_q;
    end else begin : g_comb
        logic clk_unused;
        assign clk_unused = clk ^ rst_n;
        assign out_valid = in_valid;
        assign a_o = a_i;
        assign b_o = b_i;
    end
endmodule

// File: rtl/byte_shuffle_net.sv
`timescale 1ns/1ps
module byte_shuffle_net #(
    parameter int NBYTES = 16,
    parameter bit REGISTERED = 1'b1,
    localparam int W = NBYTES * shuf_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W-1:0]      vec_a,
    input  logic [W-1:0]      vec_b,
    input  logic [NBYTES-1:0] ctrl,
    input  logic              same_operand,
    output logic              out_valid,
    output logic [W-1:0]      out_a,
    output logic [W-1:0]      out_b
);
    logic [W-1:0] src_b, net_a, net_b;

    // aliased operands: two value copies of vec_a
    assign src_b = same_operand ? vec_a : vec_b;

    shuf_net #(.NBYTES(NBYTES)) net_i (
        .ctrl (ctrl),
        .a_i  (vec_a),
        .b_i  (src_b),
        .a_o  (net_a),
        .b_o  (net_b)
    );

    shuf_outreg #(.W(W), .REGISTERED(REGISTERED)) oreg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .a_i       (net_a),
        .b_i       (net_b),
        .out_valid (out_valid),
        .a_o       (out_a),
        .b_o       (out_b)
    );
endmodule

// File: rtl/byte_shuffle_chk.sv
`timescale 1ns/1ps
module byte_shuffle_chk #(
    parameter int NBYTES = 16,
    parameter bit REGISTERED = 1'b1,
    localparam int W = NBYTES * 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [W-1:0]      vec_a,
    input logic [W-1:0]      vec_b,
    input logic [NBYTES-1:0] ctrl,
    input logic              same_operand,
    input logic              out_valid,
    input logic [W-1:0]      out_a,
    input logic [W-1:0]      out_b
);
    localparam logic [NBYTES-1:0] MASK = NBYTES'(shuf_pkg::stride_mask(NBYTES));

    function automatic logic [7:0] fold(input logic [W-1:0] v);
        logic [7:0] r;
        r = '0;
        for (int k = 0; k < NBYTES; k++) r = r ^ v[k*8 +: 8];
        return r;
    endfunction

    logic [7:0] in_fold, out_fold;
    assign in_fold  = same_operand ? 8'h00 : fold(vec_a ^ vec_b);
    assign out_fold = fold(out_a ^ out_b);

    if (REGISTERED) begin : g_props
        // R7
        valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        // R7
        valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // R8
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(out_a) && $stable(out_b)));
        // R5
        zero_ctrl_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && ((ctrl & MASK) == '0) && !same_operand)
            |=> (out_a == $past(vec_a) && out_b == $past(vec_b)));
        // R10
        byte_xor_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_fold == $past(in_fold)));
    end
endmodule

bind byte_shuffle_net byte_shuffle_chk #(.NBYTES(NBYTES), .REGISTERED(REGISTERED)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vec_a(vec_a), .vec_b(vec_b),
    .ctrl(ctrl), .same_operand(same_operand), .out_valid(out_valid),
    .out_a(out_a), .out_b(out_b)
);

// File: tb/byte_shuffle_net_tb_top.sv
`timescale 1ns/1ps
module byte_shuffle_net_tb_top;
    localparam int N = 16;
    localparam int W = N * 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] vec_a = '0, vec_b = '0;
    logic [N-1:0] ctrl = '0;
    logic         same_operand = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_a, out_b;

    int n_checks = 0;
    int n_fail = 0;
    logic         exp_valid = 1'b0;
    logic [W-1:0] exp_a = '0, exp_b = '0;
    string        exp_tag = "R9";

    always #2.5 clk = ~clk;

    byte_shuffle_net #(.NBYTES(N), .REGISTERED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vec_a(vec_a), .vec_b(vec_b),
        .ctrl(ctrl), .same_operand(same_operand), .out_valid(out_valid),
        .out_a(out_a), .out_b(out_b)
    );

    // behavioural model: byte arrays, strides taken smallest first
    function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic [N-1:0] c, input bit same,
                                  output logic [W-1:0] oa, output logic [W-1:0] ob);
        logic [7:0] x [N];
        logic [7:0] y [N];
        logic [7:0] t;
        for (int k = 0; k < N; k++) begin
            x[k] = a[k*8 +: 8];
            y[k] = same ? a[k*8 +: 8] : b[k*8 +: 8];
        end
        for (int s = 1; s < N; s = s * 2) begin
            if (c[s]) begin
                for (int k = 0; k < N; k++) begin
                    if ((k & s) == 0) begin
                        t = x[k]; x[k] = y[k+s]; y[k+s] = t;
                    end
                end
            end
        end
        for (int k = 0; k < N; k++) begin
            oa[k*8 +: 8] = x[k];
            ob[k*8 +: 8] = y[k];
        end
    endfunction

    function automatic logic [7:0] xfold(input logic [W-1:0] v);
        logic [7:0] r = '0;
        for (int k = 0; k < N; k++) r = r ^ v[k*8 +: 8];
        return r;
    endfunction

    function automatic logic [W-1:0] ramp(input int base);
        logic [W-1:0] v;
        for (int k = 0; k < N; k++) v[k*8 +: 8] = 8'(base + k);
        return v;
    endfunction

    task automatic compare();
        n_checks++;
        if (out_valid !== exp_valid || out_a !== exp_a || out_b !== exp_b) begin
            n_fail++;
            $display("FAIL %s: valid=%0b a=%h b=%h expected valid=%0b a=%h b=%h",
                     exp_tag, out_valid, out_a, out_b, exp_valid, exp_a, exp_b);
        end
        if (exp_tag == "R10" && out_valid === 1'b1) begin
            n_checks++;
            if (xfold(out_a ^ out_b) !== xfold(exp_a ^ exp_b)) begin
                n_fail++;
                $display("FAIL R10: fold=%h expected %h",
                         xfold(out_a ^ out_b), xfold(exp_a ^ exp_b));
            end
        end
    endtask

    // one clock: check the previous result, then present new inputs
    task automatic step(input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [N-1:0] c, input bit same, input string tag);
        @(negedge clk);
        compare();
        in_valid = v; vec_a = a; vec_b = b; ctrl = c; same_operand = same;
        exp_valid = v;
        if (v) begin
            model(a, b, c, same, exp_a, exp_b);
            exp_tag = tag;
        end else begin
            exp_tag = "R8";
        end
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        compare();
        rst_n = 1'b1;
        // R5: zero control
        step(1, ramp(8'h00), ramp(8'h80), '0, 0, "R5");
        step(1, ramp(8'h40), ramp(8'hC0), '0, 0, "R5");
        // R2/R3: each stride alone (bits 1,2,4,8)
        for (int g = 0; g < 4; g++) begin
            step(1, ramp(8'h10 * g), ramp(8'h90 + g), N'(1 << (1 << g)), 0, "R3");
        end
        // R8: idle with changing inputs, outputs must hold
        step(0, ramp(8'h33), ramp(8'h77), 16'hFFFF, 0, "R8");
        step(0, ramp(8'h55), ramp(8'h11), 16'h0116, 1, "R8");
        // R4: only non-stride bits set behaves as identity
        step(1, ramp(8'h01), ramp(8'hA1), 16'hFEE9, 0, "R4");
        step(1, ramp(8'h21), ramp(8'hB1), 16'hFEE9 | 16'h0004, 0, "R4");
        // R1: all strides, order matters
        step(1, ramp(8'h00), ramp(8'h80), 16'h0116, 0, "R1");
        step(1, ramp(8'h00), ramp(8'h80), 16'h0006, 0, "R1");
        step(1, ramp(8'h00), ramp(8'h80), 16'h0112, 0, "R1");
        // R6: aliased operand, vec_b is garbage
        step(1, ramp(8'h5C), {W/32{32'hDEADBEEF}}, 16'h0116, 1, "R6");
        step(1, {N/4{32'h089BE55C}}, {N/4{32'h12345678}}, 16'h0926, 1, "R6");
        step(1, ramp(8'h70), ramp(8'h00), 16'h0000, 1, "R6");
        // R7: back-to-back then drain
        step(1, ramp(8'h90), ramp(8'h10), 16'h0014, 0, "R7");
        step(1, ramp(8'hA0), ramp(8'h20), 16'h0102, 0, "R7");
        step(0, '0, '0, '0, 0, "R7");
        step(0, '0, '0, '0, 0, "R7");
        // R10 and R1: random mixes with bursts and gaps
        for (int i = 0; i < 120; i++) begin
            step(($urandom % 4) != 0, {$urandom, $urandom, $urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom}, N'($urandom),
                 ($urandom % 5) == 0, "R10");
        end
        step(0, '0, '0, '0, 0, "R8");
        @(negedge clk);
        compare();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule